// File: doc/BRIEF.md
# Feedback-Clock SPI Receive Capture

This block captures the receive side of an SPI controller link. The clock is not taken from the controller's own clock generator. It is taken from a copy of the SPI clock that has been routed back from the pins. That copy travels next to the returning data lines, so both see the same board and pad delays. A fast link can therefore run with a round-trip delay longer than half a clock period. Up to four data lanes are sampled in parallel. Each lane assembles its own sequence of 8-bit or 16-bit words, MSB-first or LSB-first, on the sampling edge that the SPI mode selects.

The looped-back clock, the chip select and the data lanes all pass through the same two-flop synchronizer into the system clock. Edges of the clock are found after synchronization. Data is taken from the same synchronized stage on which the edge is seen, so clock and data keep their relative timing. While chip select is low, every edge of the clock (rising and falling) is counted. When chip select rises, the count is compared with twice the number of bits in the burst. On a match, the captured words are copied to the output registers and the valid flag is raised. On a mismatch, the valid flag drops and the outputs keep the last good burst. When feedback checking is switched off, the valid flag stays high and every burst is copied out.

Top module: `fbspi_rx_capture`

## Requirements
- R1: A bit is sampled on a rising edge of the feedback clock when `cfg_mode` ({polarity, phase}) is 2'b00 or 2'b11, and on a falling edge when it is 2'b01 or 2'b10; the other edge samples nothing.
- R2: With `cfg_lsb_first`=1 the first bit received in a word lands in bit 0 of that word; with 0 it lands in the word's top bit (bit 7 or bit 15).
- R3: With `cfg_wide`=0 words are 8 bits and sit in the low byte of a 16-bit slot whose upper byte reads 0; with `cfg_wide`=1 words are 16 bits. Word k of lane l appears at `rx_data[(l*MAX_WORDS+k)*16 +: 16]`; slots at or above `cfg_words` read 0.
- R4: While chip select is low, both edges of the feedback clock are counted. When chip select rises with feedback checking on, a count equal to 2 × word length × `cfg_words` sets `rx_valid`=1 and copies the burst to `rx_data`.
- R5: When chip select rises with feedback checking on and the count differs from that value (too few or too many edges), `rx_valid` goes to 0 and `rx_data` keeps its previous contents.
- R6: Feedback clock edges that occur while chip select is high are neither counted nor sampled, and the count starts again from zero in every chip select low window.
- R7: With `cfg_enable`=0, `rx_valid` is 1 from the cycle after the input goes low, and every burst is copied to `rx_data` whatever its edge count; missing bits read 0.
- R8: `rx_done` pulses high for exactly one cycle, three clock edges after the `cs_n` pin rises, and `rx_valid`/`rx_data` carry that burst's result in the same cycle.
- R9: After reset, `rx_valid`=0 (with feedback checking on), `rx_done`=0 and `rx_data` is all zeros.
- R10: Each lane assembles its words from its own data input only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | 1: check the feedback edge count; 0: always valid |
| cfg_mode | input | 2 | SPI mode as {polarity, phase} |
| cfg_wide | input | 1 | 0: 8-bit words, 1: 16-bit words |
| cfg_lsb_first | input | 1 | 1: LSB received first, 0: MSB first |
| cfg_words | input | $clog2(MAX_WORDS+1) | Words per lane per burst (1..MAX_WORDS) |
| cs_n | input | 1 | Chip select as driven by the controller, active low |
| fb_sclk | input | 1 | SPI clock looped back from the pins |
| miso | input | LANES | Receive data lanes |
| rx_valid | output | 1 | Last burst had the expected edge count |
| rx_done | output | 1 | One-cycle pulse at the end of each burst |
| rx_data | output | LANES*MAX_WORDS*16 | Captured words, 16-bit slot per word |

## Verification
The bench builds the block with all four lanes and MAX_WORDS=3. That makes it possible to fill every slot with 16-bit words and to leave slots empty with shorter bursts. It runs all four modes, both word lengths and both bit orders, with different patterns on each lane. It then sends bursts that are one bit short and one bit long, clock toggles while chip select is high, and a short burst with checking disabled. A scoreboard confirms whether the stored data is kept or replaced after each burst.

// File: rtl/fbspi_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the feedback-clock SPI receive capture.
// Assumes every word occupies one 16-bit slot whatever its configured length.
package fbspi_pkg;
    localparam int SLOT_BITS = 16;
    localparam int SYNC_DEPTH = 2;

    // Mode encoding is {polarity, phase}; modes 00 and 11 sample on a rising edge.
    function automatic logic samples_on_rise(input logic [1:0] mode);
        return (mode == 2'b00) || (mode == 2'b11);
    endfunction
endpackage

// File: rtl/fbspi_sync.sv
`timescale 1ns/1ps
// Module: fbspi_sync
// Multi-bit flop chain that brings asynchronous pins into the system clock.
// Assumes all bits are sampled together so their relative order is kept;
// each bit resets to its own value from RST_VAL.
module fbspi_sync #(
    parameter int W = 1,
    parameter int DEPTH = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [DEPTH];

    // Shift the raw pins through DEPTH flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[DEPTH-1];
endmodule

// File: rtl/fbspi_edge.sv
`timescale 1ns/1ps
// Module: fbspi_edge
// Finds edges of the synchronized feedback clock and flags the ones the
// SPI mode uses for sampling. Assumes sclk_s is already synchronous.
module fbspi_edge
    import fbspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s,
    input  logic [1:0] mode,
    output logic       any_edge,
    output logic       samp_edge
);
    logic sclk_prev;
    logic rise, fall;

    // Keep the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    // Classify the current cycle's transition.
    always_comb begin
        rise      = sclk_s & ~sclk_prev;
        fall      = ~sclk_s & sclk_prev;
        any_edge  = rise | fall;
        samp_edge = samples_on_rise(mode) ? rise : fall;
    end
endmodule

// File: rtl/fbspi_lane.sv
`timescale 1ns/1ps
// Module: fbspi_lane
// One receive lane: a capture buffer written bit by bit during a burst and
// an output register loaded from it when a burst is accepted.
// Assumes clear and wr never coincide (the parent gives clear priority).
module fbspi_lane #(
    parameter int SLOT_W = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              bit_in,
    input  logic              commit,
    output logic [SLOT_W-1:0] words
);
    logic [SLOT_W-1:0] cap_q;
    logic [SLOT_W-1:0] out_q;

    // Capture buffer: emptied at burst start, one bit written per sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cap_q <= '0;
        else if (wr)         cap_q[wr_addr] <= bit_in;
    end

    // Output register: loaded only for an accepted burst.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (commit) out_q <= cap_q;
    end

    assign words = out_q;

    // R6: a new burst starts from an empty buffer.
    p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cap_q == '0));

    // R4: an accepted burst shows exactly what was captured.
    p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (out_q == $past(cap_q)));
endmodule

// File: rtl/fbspi_rx_capture.sv
`timescale 1ns/1ps
// Module: fbspi_rx_capture
// Receive capture for an SPI controller clocked by the looped-back SPI clock.
// Synchronizes chip select, feedback clock and lanes together, samples on
// the mode's edge, counts all edges per chip-select-low window, and at the
// end of the burst accepts or rejects it by edge count.
// Assumes cfg_* are stable while chip select is low.
module fbspi_rx_capture
    import fbspi_pkg::*;
#(
    parameter int LANES = 4,
    parameter int MAX_WORDS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_enable,
    input  logic [1:0]                         cfg_mode,
    input  logic                               cfg_wide,
    input  logic                               cfg_lsb_first,
    input  logic [$clog2(MAX_WORDS+1)-1:0]     cfg_words,
    input  logic                               cs_n,
    input  logic                               fb_sclk,
    input  logic [LANES-1:0]                   miso,
    output logic                               rx_valid,
    output logic                               rx_done,
    output logic [LANES*MAX_WORDS*SLOT_BITS-1:0] rx_data
);
    localparam int SLOT_W = MAX_WORDS * SLOT_BITS;
    localparam int ADDR_W = $clog2(SLOT_W);
    localparam int IDX_W  = ADDR_W + 1;
    localparam int CNT_W  = $clog2(2 * SLOT_W) + 1;
    localparam int SW     = LANES + 2;

    logic [SW-1:0]    sync_q;
    logic             cs_s, sclk_s;
    logic [LANES-1:0] miso_s;
    logic             any_edge, samp_edge;
    logic             cs_prev, cs_fall, cs_rise;
    logic [CNT_W-1:0] edge_cnt, exp_cnt;
    logic [IDX_W-1:0] samp_idx, cap_bits, wsel, addr_full;
    logic [3:0]       bsel, pos;
    logic [ADDR_W-1:0] wr_addr;
    logic             wr, count_ok, commit;
    logic             valid_q, done_q;

    fbspi_sync #(
        .W(SW), .DEPTH(SYNC_DEPTH),
        .RST_VAL({1'b1, 1'b0, {LANES{1'b0}}})
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({cs_n, fb_sclk, miso}),
        .q_sync(sync_q)
    );

    assign {cs_s, sclk_s, miso_s} = sync_q;

    fbspi_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .mode(cfg_mode),
        .any_edge(any_edge), .samp_edge(samp_edge)
    );

    // Previous chip select level for burst start/end detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= cs_s;
    end

    // Burst boundaries, expected count and capture address.
    always_comb begin
        cs_fall   = ~cs_s & cs_prev;
        cs_rise   = cs_s & ~cs_prev;
        exp_cnt   = CNT_W'(cfg_words) << (cfg_wide ? 5 : 4);
        cap_bits  = IDX_W'(cfg_words) << (cfg_wide ? 4 : 3);
        wsel      = cfg_wide ? (samp_idx >> 4) : (samp_idx >> 3);
        bsel      = cfg_wide ? samp_idx[3:0] : {1'b0, samp_idx[2:0]};
        pos       = cfg_lsb_first ? bsel : ((cfg_wide ? 4'd15 : 4'd7) - bsel);
        addr_full = (wsel << 4) | IDX_W'(pos);
        wr_addr   = addr_full[ADDR_W-1:0];
        wr        = ~cs_s & samp_edge & ~cs_fall & (samp_idx < cap_bits);
        count_ok  = ~cfg_enable | (edge_cnt == exp_cnt);
        commit    = cs_rise & count_ok;
    end

    // Count both feedback edges inside a chip-select-low window, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s)                     edge_cnt <= '0;
        else if (any_edge && (edge_cnt != '1))  edge_cnt <= edge_cnt + 1'b1;
    end

    // Count sampling edges to address the next bit, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s)                     samp_idx <= '0;
        else if (samp_edge && (samp_idx != '1)) samp_idx <= samp_idx + 1'b1;
    end

    // Valid flag and end-of-burst pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= cs_rise;
            if (!cfg_enable)  valid_q <= 1'b1;
            else if (cs_rise) valid_q <= count_ok;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            fbspi_lane #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .clear(cs_fall), .wr(wr), .wr_addr(wr_addr),
                .bit_in(miso_s[g]), .commit(commit),
                .words(rx_data[g*SLOT_W +: SLOT_W])
            );
        end
    endgenerate

    assign rx_valid = valid_q;
    assign rx_done  = done_q;

    // R8: end-of-burst indication lasts one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R5: a rejected burst leaves the data untouched.
    p_keep_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_valid) |-> $stable(rx_data));

    // R7: checking disabled forces the valid flag high.
    p_disabled_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> rx_valid);

    // R6: no edge is counted while chip select is high.
    p_idle_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (edge_cnt == '0));

    // R4: within a burst the edge count never goes backwards.
    p_count_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !cs_prev) |-> (edge_cnt >= $past(edge_cnt)));
endmodule

// File: tb/fbspi_rx_capture_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected result of each burst,
// the monitor pops and compares at every rx_done pulse.
module fbspi_rx_capture_test;
    localparam int LANES = 4;
    localparam int MAXW  = 3;
    localparam int DW    = LANES * MAXW * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b1;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cfg_wide = 1'b0;
    logic          cfg_lsb_first = 1'b0;
    logic [1:0]    cfg_words = 2'd1;
    logic          cs_n = 1'b1;
    logic          fb_sclk = 1'b0;
    logic [LANES-1:0] miso = '0;
    logic          rx_valid, rx_done;
    logic [DW-1:0] rx_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [DW:0] exp_q [$];
    logic [DW-1:0] last_good = '0;
    logic [15:0] wd [LANES][MAXW];

    always #2.5 clk = ~clk;

    fbspi_rx_capture #(.LANES(LANES), .MAX_WORDS(MAXW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first), .cfg_words(cfg_words),
        .cs_n(cs_n), .fb_sclk(fb_sclk), .miso(miso),
        .rx_valid(rx_valid), .rx_done(rx_done), .rx_data(rx_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Monitor: compare each burst result with the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_done) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R8: unexpected rx_done, actual 1 expected 0");
                end else begin
                    logic [DW:0] e;
                    e = exp_q.pop_front();
                    check("R4/R5/R7 valid", DW'(rx_valid), DW'(e[DW]));
                    check("R1/R2/R3/R10 data", rx_data, e[DW-1:0]);
                end
            end
        end
    end

    // Expected image of the configured words (R3 slot layout).
    function automatic logic [DW-1:0] image(input int nw, input logic wide);
        logic [DW-1:0] v = '0;
        for (int l = 0; l < LANES; l++)
            for (int k = 0; k < nw; k++)
                v[(l*MAXW+k)*16 +: 16] = wide ? wd[l][k] : {8'h00, wd[l][k][7:0]};
        return v;
    endfunction

    // Driver half: push the expectation for the burst about to be sent.
    task automatic push_expect(input logic v, input logic [DW-1:0] d);
        exp_q.push_back({v, d});
        if (v) last_good = d;
    endtask

    // Send one burst with bit count altered by delta (-1, 0, +1).
    task automatic burst(input logic [1:0] mode, input logic wide, input logic lsb,
                         input int nw, input int delta, input logic pre_toggle);
        int len = wide ? 16 : 8;
        int total = len * nw + delta;
        @(negedge clk);
        cfg_mode = mode; cfg_wide = wide; cfg_lsb_first = lsb;
        cfg_words = 2'(nw); fb_sclk = mode[1];
        repeat (6) @(negedge clk);
        if (pre_toggle) begin   // R6: edges with chip select high
            repeat (2) begin fb_sclk = ~fb_sclk; repeat (4) @(negedge clk); end
        end
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int n = 0; n < total; n++) begin
            logic [LANES-1:0] bits = '0;
            int k = n / len;
            int b = n % len;
            for (int l = 0; l < LANES; l++)
                if (k < nw) bits[l] = wd[l][k][lsb ? b : len-1-b];
            if (mode[0] == 1'b0) begin
                miso = bits; repeat (4) @(negedge clk);
                fb_sclk = ~fb_sclk; repeat (4) @(negedge clk);
                fb_sclk = ~fb_sclk; repeat (4) @(negedge clk);
            end else begin
                fb_sclk = ~fb_sclk; repeat (2) @(negedge clk);
                miso = bits; repeat (2) @(negedge clk);
                fb_sclk = ~fb_sclk; repeat (4) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic fill(input logic [15:0] seed);
        for (int l = 0; l < LANES; l++)
            for (int k = 0; k < MAXW; k++)
                wd[l][k] = seed ^ 16'(l * 16'h1357 + k * 16'h0F0F + l * k * 16'h2468);
    endtask

    initial begin
        logic [DW-1:0] e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 valid", DW'(rx_valid), '0);
        check("R9 done", DW'(rx_done), '0);
        check("R9 data", rx_data, '0);

        // R1 mode 00, R2 MSB first, R3 8-bit, unused slot zero, R10 lanes differ
        fill(16'hA5C3);
        push_expect(1'b1, image(2, 1'b0));
        burst(2'b00, 1'b0, 1'b0, 2, 0, 1'b0);

        // R1 mode 01, R2 LSB first, R3 16-bit, all slots
        fill(16'h3C96);
        push_expect(1'b1, image(3, 1'b1));
        burst(2'b01, 1'b1, 1'b1, 3, 0, 1'b0);

        // R1 mode 10, 8-bit LSB first, single word
        fill(16'h5E21);
        push_expect(1'b1, image(1, 1'b0));
        burst(2'b10, 1'b0, 1'b1, 1, 0, 1'b0);

        // R1 mode 11, 16-bit MSB first
        fill(16'hC807);
        push_expect(1'b1, image(2, 1'b1));
        burst(2'b11, 1'b1, 1'b0, 2, 0, 1'b0);

        // R5: one bit short, data kept
        fill(16'h1111);
        push_expect(1'b0, last_good);
        burst(2'b00, 1'b1, 1'b0, 2, -1, 1'b0);

        // R5: one bit extra, data kept
        fill(16'h7777);
        push_expect(1'b0, last_good);
        burst(2'b11, 1'b0, 1'b1, 3, 1, 1'b0);

        // R6: toggles while chip select high are ignored; good burst accepted
        fill(16'h9BE4);
        push_expect(1'b1, image(3, 1'b0));
        burst(2'b01, 1'b0, 1'b0, 3, 0, 1'b1);

        // R7: checking disabled
        @(negedge clk); cfg_enable = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 idle valid", DW'(rx_valid), DW'(1));
        fill(16'h46D2);
        e = image(2, 1'b1);
        for (int l = 0; l < LANES; l++) e[(l*MAXW+1)*16 + 0] = 1'b0; // last MSB-first bit lost
        push_expect(1'b1, e);
        burst(2'b10, 1'b1, 1'b0, 2, -1, 1'b0);

        // R4 again after re-enable
        @(negedge clk); cfg_enable = 1'b1;
        fill(16'hE01F);
        push_expect(1'b1, image(1, 1'b1));
        burst(2'b00, 1'b1, 1'b1, 1, 0, 1'b0);

        repeat (10) @(negedge clk);
        // R8: every expected burst produced exactly one rx_done
        check("R8 pending", DW'(exp_q.size()), '0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule